// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns the 16-bit address of an 8-bit processor into physical addresses for two larger memories: a 512 KB battery-backed RAM and a 32 KB boot EEPROM. A single 8-bit page register, which the processor writes over its own bus, holds three fields. The low four bits choose which 32 KB RAM page appears in the lower half of the processor's address space. The next three bits choose which 4 KB bank of the EEPROM appears in the ROM window. The top bit drives a status LED.

Only the lower 32 KB processor window is swapped. Addresses in the upper half always reach physical RAM page 15, so the RAM the processor sees stays contiguous. A strap input lets a 128 KB RAM sit in the same socket. In that mode the two top physical lines are forced so that the smaller part is enabled, and only two page bits take part in the mapping. Chip-select timing and I/O decoding are handled elsewhere. The block only needs `reg_sel`, which is high when the bus address decodes to the page register.

Writes are tracked by a small state machine clocked by the system clock, with the bus enable `bus_e` sampled as an input. `ST_IDLE` waits for a bus cycle to the register. `ST_IDLE -> ST_WRITE` happens when `bus_e`, `reg_sel` and write (`cpu_rw` low) are all seen together. `ST_IDLE -> ST_READ_HOLD` happens when `bus_e` and `reg_sel` are seen with `cpu_rw` high. `ST_WRITE` keeps copying the data bus into a staging register while `bus_e` stays high. `ST_WRITE -> ST_IDLE` happens on the first cycle with `bus_e` low, and that transition commits the staged byte to the page register. `ST_READ_HOLD -> ST_IDLE` happens when `bus_e` falls, and nothing is written.

Top module: `bank_xlate`

## Requirements
- R1: After reset the page register reads 0x00, `led` is 0, RAM page 0 is mapped to the lower half and EEPROM bank 0 is mapped to the ROM window.
- R2: A write bus cycle (`bus_e`=1, `reg_sel`=1, `cpu_rw`=0 when the cycle starts) leaves `page_value` unchanged while `bus_e` is high. `page_value` takes the new byte on the clock edge that first samples `bus_e` low.
- R3: The page register does not change without a write cycle. This includes `reg_sel` low with `bus_e` high, and `reg_sel` high with `cpu_rw` low while `bus_e` stays low.
- R4: A read bus cycle to the register address (`cpu_rw`=1) never alters the page register.
- R5: `page_value` shows the whole register. `led` equals register bit 7.
- R6: In 512 KB mode (`ram_small`=0), a CPU address with bit 15 clear maps to `ram_addr` = {page[3:0], cpu_addr[14:0]}.
- R7: In 512 KB mode, a CPU address with bit 15 set maps to `ram_addr` = {4'hF, cpu_addr[14:0]} whatever the page register holds.
- R8: `rom_addr` = {page[6:4], cpu_addr[11:0]}.
- R9: In 128 KB mode (`ram_small`=1), `ram_addr[18]`=0 and `ram_addr[17]`=1. `ram_addr[16:15]` is page[1:0] for the lower half and 2'b11 for the upper half. `ram_addr[14:0]` is `cpu_addr[14:0]`.
- R10: Once a write cycle has started, the byte committed is the last value on `cpu_data` while `bus_e` was high. Changes on `reg_sel` or `cpu_rw` after the start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| bus_e | input | 1 | Bus enable strobe, sampled on clk |
| reg_sel | input | 1 | Page register address decoded |
| ram_small | input | 1 | 1 = 128 KB RAM fitted |
| ram_addr | output | 19 | Physical RAM address |
| rom_addr | output | 15 | Physical EEPROM address |
| page_value | output | 8 | Current page register contents |
| led | output | 1 | Status LED drive |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, a 4-bit RAM page field, a 3-bit EEPROM bank field, a 12-bit ROM window and 2 page bits kept in small-RAM mode. With these values the field boundaries land on the physical lines the requirements name. This lets the bench check page 15 against the fixed upper segment, the forced top lines in 128 KB mode and EEPROM bank 4 against exact addresses. It also exercises bus cycles whose data, select or direction change while the strobe is high.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITE     = 2'd1,
        ST_READ_HOLD = 2'd2
    } pg_state_e;
endpackage

// File: rtl/bxl_page_reg.sv
module bxl_page_reg
    import bank_xlate_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rw,
    input  logic              bus_e,
    input  logic              reg_sel,
    output logic [DATA_W-1:0] page_q
);
    pg_state_e         state_q, state_d;
    logic [DATA_W-1:0] stage_q, stage_d;
    logic [DATA_W-1:0] page_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
            page_q  <= page_d;
        end
    end

    // next state and register loads
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        page_d  = page_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_e && reg_sel) begin
                    if (cpu_rw) begin
                        state_d = ST_READ_HOLD;
                    end else begin
                        state_d = ST_WRITE;
                        stage_d = cpu_data;
                    end
                end
            end
            ST_WRITE: begin
                if (bus_e) begin
                    stage_d = cpu_data;
                end else begin
                    page_d  = stage_q;
                    state_d = ST_IDLE;
                end
            end
            ST_READ_HOLD: begin
                if (!bus_e) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_WRITE && !bus_e) |=> $stable(page_q)); // R3
    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_HOLD) |=> $stable(page_q)); // R4
    AST_COMMIT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !bus_e) |=> (state_q == ST_IDLE)); // R2
endmodule

// File: rtl/bxl_ram_map.sv
module bxl_ram_map #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int SMALL_W = 2
) (
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [PAGE_W-1:0]          page_ram,
    input  logic                       ram_small,
    output logic [ADDR_W-1+PAGE_W-1:0] ram_addr
);
    localparam int WIN_W  = ADDR_W - 1;
    localparam int RAM_AW = WIN_W + PAGE_W;

    logic              upper_half;
    logic [PAGE_W-1:0] page_eff;

    assign upper_half = cpu_addr[WIN_W];

    always_comb begin
        // upper half is steered to the last page, never the register
        page_eff = upper_half ? {PAGE_W{1'b1}} : page_ram;
        if (ram_small) begin
            for (int i = SMALL_W; i < PAGE_W; i++) page_eff[i] = 1'b0;
            // line above the kept bits is driven inverted (high enable on small part)
            page_eff[SMALL_W] = 1'b1;
        end
        ram_addr = {page_eff, cpu_addr[WIN_W-1:0]};
    end

    always_comb begin
        if (upper_half && !ram_small)
            AST_UPPER_FIXED: assert (ram_addr[RAM_AW-1:WIN_W] == {PAGE_W{1'b1}}); // R7
        if (ram_small)
            AST_SMALL_TOP: assert (!ram_addr[RAM_AW-1] && ram_addr[WIN_W+SMALL_W]); // R9
    end
endmodule

// File: rtl/bxl_rom_map.sv
module bxl_rom_map #(
    parameter int BANK_W = 3,
    parameter int ROM_WIN_W = 12
) (
    input  logic [ROM_WIN_W-1:0]        win_addr,
    input  logic [BANK_W-1:0]           bank,
    output logic [BANK_W+ROM_WIN_W-1:0] rom_addr
);
    assign rom_addr = {bank, win_addr};
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 4,
    parameter int BANK_W    = 3,
    parameter int ROM_WIN_W = 12,
    parameter int SMALL_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [PAGE_W+BANK_W:0]        cpu_data,
    input  logic                          cpu_rw,
    input  logic                          bus_e,
    input  logic                          reg_sel,
    input  logic                          ram_small,
    output logic [ADDR_W-1+PAGE_W-1:0]    ram_addr,
    output logic [BANK_W+ROM_WIN_W-1:0]   rom_addr,
    output logic [PAGE_W+BANK_W:0]        page_value,
    output logic                          led
);
    localparam int DATA_W  = PAGE_W + BANK_W + 1;
    localparam int BANK_LO = PAGE_W;
    localparam int LED_BIT = DATA_W - 1;

    logic [DATA_W-1:0] page_q;

    bxl_page_reg #(.DATA_W(DATA_W)) u_page (
        .clk(clk), .rst_n(rst_n), .cpu_data(cpu_data), .cpu_rw(cpu_rw),
        .bus_e(bus_e), .reg_sel(reg_sel), .page_q(page_q)
    );

    bxl_ram_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SMALL_W(SMALL_W)) u_ram (
        .cpu_addr(cpu_addr), .page_ram(page_q[PAGE_W-1:0]),
        .ram_small(ram_small), .ram_addr(ram_addr)
    );

    bxl_rom_map #(.BANK_W(BANK_W), .ROM_WIN_W(ROM_WIN_W)) u_rom (
        .win_addr(cpu_addr[ROM_WIN_W-1:0]), .bank(page_q[BANK_LO+BANK_W-1:BANK_LO]),
        .rom_addr(rom_addr)
    );

    assign page_value = page_q;
    assign led        = page_q[LED_BIT];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (page_value == '0)); // R1
endmodule

// File: tb/bank_xlate_bench.sv
module bank_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        bus_e = 1'b0;
    logic        reg_sel = 1'b0;
    logic        ram_small = 1'b0;
    logic [18:0] ram_addr;
    logic [14:0] rom_addr;
    logic [7:0]  page_value;
    logic        led;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_xlate u_bank_xlate (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .bus_e(bus_e), .reg_sel(reg_sel), .ram_small(ram_small),
        .ram_addr(ram_addr), .rom_addr(rom_addr), .page_value(page_value), .led(led)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    // one complete bus cycle: strobe high for 3 clocks, then low
    task automatic bus_cycle(input logic sel, input logic rw, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; cpu_rw = rw; cpu_data = d; bus_e = 1'b1;
        repeat (3) @(negedge clk);
        bus_e = 1'b0;
        @(negedge clk);
        reg_sel = 1'b0; cpu_rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 page", page_value, 8'h00);
        check("R1 led", led, 1'b0);
        look(16'h1234); check("R1 ram page0", ram_addr, 19'h01234);
        look(16'hF123); check("R1 rom bank0", rom_addr, 15'h0123);
    endtask

    task automatic t_write_fields();
        @(negedge clk);
        reg_sel = 1'b1; cpu_rw = 1'b0; cpu_data = 8'hA5; bus_e = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 held while E high", page_value, 8'h00);
        bus_e = 1'b0;
        @(negedge clk);
        check("R2 commit on E fall", page_value, 8'hA5);
        check("R5 led bit7", led, 1'b1);
        reg_sel = 1'b0; cpu_rw = 1'b1;
        look(16'h1234); check("R6 lower map", ram_addr, 19'h29234);
        look(16'h7FFF); check("R6 lower top", ram_addr, 19'h2FFFF);
        look(16'hF0AB); check("R8 rom bank2", rom_addr, 15'h20AB);
    endtask

    task automatic t_upper();
        look(16'h8000); check("R7 upper base", ram_addr, 19'h78000);
        look(16'hDFFF); check("R7 upper top", ram_addr, 19'h7DFFF);
        bus_cycle(1'b1, 1'b0, 8'h03);
        look(16'hC000); check("R7 upper ignores page", ram_addr, 19'h7C000);
        look(16'h0000); check("R6 page3", ram_addr, 19'h18000);
    endtask

    task automatic t_read();
        bus_cycle(1'b1, 1'b1, 8'h3C);
        check("R4 read keeps page", page_value, 8'h03);
        look(16'h0010); check("R4 map unchanged", ram_addr, 19'h18010);
    endtask

    task automatic t_no_write();
        bus_cycle(1'b0, 1'b0, 8'h77);
        check("R3 no select", page_value, 8'h03);
        @(negedge clk);
        reg_sel = 1'b1; cpu_rw = 1'b0; cpu_data = 8'h66;
        repeat (4) @(negedge clk);
        reg_sel = 1'b0; cpu_rw = 1'b1;
        @(negedge clk);
        check("R3 no strobe", page_value, 8'h03);
    endtask

    task automatic t_late_data();
        @(negedge clk);
        reg_sel = 1'b1; cpu_rw = 1'b0; cpu_data = 8'h11; bus_e = 1'b1;
        @(negedge clk);
        reg_sel = 1'b0; cpu_rw = 1'b1; cpu_data = 8'h42;
        @(negedge clk);
        bus_e = 1'b0; cpu_data = 8'h99;
        @(negedge clk);
        check("R10 last data while E high", page_value, 8'h42);
        look(16'hFFFF); check("R8 rom bank4", rom_addr, 15'h4FFF);
    endtask

    task automatic t_small();
        ram_small = 1'b1;
        look(16'h0100); check("R9 small lower", ram_addr, 19'h30100);
        look(16'h9000); check("R9 small upper", ram_addr, 19'h39000);
        bus_cycle(1'b1, 1'b0, 8'h4D);
        look(16'h0000); check("R9 small page bits1:0", ram_addr, 19'h28000);
        ram_small = 1'b0;
        look(16'h0000); check("R6 full page D", ram_addr, 19'h68000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_fields();
        t_upper();
        t_read();
        t_no_write();
        t_late_data();
        t_small();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule